// File: doc/BRIEF.md
# Configuration Cycle Router with Virtual Bridge

This block sits between a host's I/O port and the configuration paths of a host device. It holds the 32-bit configuration address register that the host programs through the address port. When the host then touches the data port, the block decodes the stored bus, device, function and register fields. It routes the access to one of five places: the host-bridge register set, the virtual bridge register set, a configuration cycle on the primary bus, a configuration cycle on the secondary graphics port, or a plain I/O cycle on the primary bus.

The virtual bridge has no physical bridge behind it. Its secondary and subordinate bus numbers come from its own register set as inputs. From those numbers the block claims and translates accesses exactly as a real bridge would. An access for the secondary bus itself becomes a Type 0 cycle with a one-hot IDSEL. An access for a bus further down becomes a Type 1 cycle with the bus number unchanged. The router completes every access with a single-cycle `io_done`. An access that no target claims completes locally. Targets reached by a strobe answer with `tgt_ack` and `tgt_rdata`.

The access sequencer moves through five states. ST_IDLE goes to ST_DECODE when a request arrives. ST_DECODE goes to ST_ISSUE when a target must be reached, and to ST_RESPOND otherwise. ST_ISSUE always goes to ST_WAIT. ST_WAIT goes to ST_RESPOND when the target acknowledges. ST_RESPOND always goes back to ST_IDLE.

Top module: `cfg_cycle_router`

## Requirements
- R1: A host write with all four byte enables to dword address 0xCF8 stores the configuration address. The enable is bit 31, the bus is bits 23:16, the device is bits 15:11, the function is bits 10:8 and the register is bits 7:2. A read with all four byte enables returns the stored value with bits 30:24 and 1:0 forced to zero. The value after reset is zero.
- R2: A request is accepted only while `io_busy` is low. Every accepted access ends with `io_done` high for exactly one cycle, after which `io_busy` is low.
- R3: Three kinds of access go out as a plain I/O cycle (`pri_io_req`), with `cyc_addr` = dword address shifted left by 2 and `cyc_type1` = 0: any access to another address, a data-port (0xCFC) access while the enable bit is clear, and an access to 0xCF8 without all four byte enables.
- R4: With the enable set and bus 0, device 0 at function 0 pulses `host_sel`, and device 1 at function 0 pulses `bridge_sel`. `cyc_addr` then carries the function in bits 10:8 and the register in bits 7:2, with every other bit zero.
- R5: Functions 1 to 7 of devices 0 and 1 on bus 0 are unimplemented. Reads return 0xFFFFFFFF and writes are dropped, and neither raises any strobe.
- R6: Bus 0 devices 2 to 20 produce a Type 0 primary cycle (`pri_cfg_req`, `cyc_type1` = 0). Its `cyc_addr` has only bit 11+device set in bits 31:11, the function in bits 10:8, the register in bits 7:2 and bits 1:0 = 00. Devices 21 to 31 are unclaimed: reads return all ones, with no strobe.
- R7: A non-zero bus equal to `sec_bus` produces a Type 0 cycle on the graphics port (`sec_cfg_req`) with the R6 address encoding, including the unclaimed rule for devices above 20.
- R8: A bus greater than `sec_bus` and no greater than `sub_bus` produces a Type 1 graphics-port cycle. Its `cyc_addr` is {8'h00, bus, device, function, register, 2'b01}.
- R9: Any other non-zero bus produces a Type 1 primary cycle with the R8 encoding.
- R10: Each forwarded access raises exactly one strobe, for one cycle. It carries the host's byte enables, write flag and write data. A forwarded read returns `tgt_rdata` as captured on `tgt_ack`. Every write returns zero on `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | Host I/O access request, one cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_dw_addr | input | 14 | Host I/O dword address (byte address bits 15:2) |
| io_be | input | 4 | Host byte-lane enables |
| io_wdata | input | 32 | Host write data |
| io_busy | output | 1 | Access in progress; requests are ignored |
| io_done | output | 1 | Access complete, one cycle |
| io_rdata | output | 32 | Read data, valid with io_done |
| sec_bus | input | 8 | Virtual bridge secondary bus number |
| sub_bus | input | 8 | Virtual bridge subordinate bus number |
| host_sel | output | 1 | Host-bridge register set strobe |
| bridge_sel | output | 1 | Virtual bridge register set strobe |
| pri_cfg_req | output | 1 | Primary bus configuration cycle request |
| sec_cfg_req | output | 1 | Graphics port configuration cycle request |
| pri_io_req | output | 1 | Primary bus plain I/O cycle request |
| cyc_type1 | output | 1 | Configuration cycle is Type 1 |
| cyc_addr | output | 32 | Encoded cycle address |
| cyc_be | output | 4 | Byte enables of the cycle |
| cyc_wr | output | 1 | Cycle is a write |
| cyc_wdata | output | 32 | Cycle write data |
| tgt_ack | input | 1 | Target completion |
| tgt_rdata | input | 32 | Target read data |

## Verification
Four properties are checked on every cycle. At most one strobe is active, and each strobe lasts one cycle. Every configuration cycle has bits 1:0 that agree with its type and a single IDSEL bit for Type 0, and internal selects always carry function 0. Every graphics-port Type 1 cycle names a bus inside the secondary-to-subordinate window. Other behaviour can only be shown by the bench's scenarios, each checked against an independent model: which target a given address reaches, the exact encoded addresses, the all-ones answer for unclaimed reads, the masking on read-back of the address register, and the boundaries at device 20/21 and at both ends of the bus window.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam int CA_W     = 32;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int REG_W    = 6;
    localparam int IDSEL_LO = 11;
    localparam int IDSEL_W  = CA_W - IDSEL_LO;
    localparam logic [CA_W-1:0] CA_KEEP = 32'h80FF_FFFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESPOND
    } state_t;

    typedef enum logic [3:0] {
        RT_ADDR_WR,
        RT_ADDR_RD,
        RT_HOST_SET,
        RT_BRIDGE_SET,
        RT_PRI_T0,
        RT_PRI_T1,
        RT_SEC_T0,
        RT_SEC_T1,
        RT_PLAIN_IO,
        RT_NONE
    } route_t;

    function automatic logic route_forwards(route_t r);
        return !(r inside {RT_ADDR_WR, RT_ADDR_RD, RT_NONE});
    endfunction

endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg
    import cfgr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CA_W-1:0] wdata,
    output logic [CA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata & CA_KEEP;
        end
    end

endmodule

// File: rtl/cfgr_route_decode.sv
module cfgr_route_decode
    import cfgr_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT  = 16'h0CFC,
    parameter int          MAX_DEV    = 20,
    parameter int          HOST_DEV   = 0,
    parameter int          BRIDGE_DEV = 1,
    localparam int         DWA_W      = IO_AW - 2
) (
    input  logic             wr,
    input  logic [DWA_W-1:0] dw_addr,
    input  logic [3:0]       be,
    input  logic             cfg_en,
    input  logic [23:2]      cfg_fields,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_t           route,
    output logic [CA_W-1:0]  enc_addr
);

    localparam logic [DWA_W-1:0] ADDR_DW = ADDR_PORT[IO_AW-1:2];
    localparam logic [DWA_W-1:0] DATA_DW = DATA_PORT[IO_AW-1:2];

    logic [BUS_W-1:0]   bus;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [REG_W-1:0]   rg;
    logic               dev_ok;
    logic [IDSEL_W-1:0] idsel;
    logic [CA_W-1:0]    t0_addr, t1_addr, int_addr, io_addr;

    assign bus    = cfg_fields[23:16];
    assign dev    = cfg_fields[15:11];
    assign fn     = cfg_fields[10:8];
    assign rg     = cfg_fields[7:2];
    assign dev_ok = (32'(dev) <= MAX_DEV);

    for (genvar g = 0; g < IDSEL_W; g++) begin : g_idsel
        if (g <= MAX_DEV) begin : g_live
            assign idsel[g] = (32'(dev) == g);
        end else begin : g_dead
            assign idsel[g] = 1'b0;
        end
    end

    assign t0_addr  = {idsel, fn, rg, 2'b00};
    assign t1_addr  = {8'h00, bus, dev, fn, rg, 2'b01};
    assign int_addr = {{IDSEL_W{1'b0}}, fn, rg, 2'b00};
    assign io_addr  = {{(CA_W-IO_AW){1'b0}}, dw_addr, 2'b00};

    always_comb begin
        route    = RT_PLAIN_IO;
        enc_addr = io_addr;
        if (dw_addr == ADDR_DW && be == 4'hF) begin
            route = wr ? RT_ADDR_WR : RT_ADDR_RD;
        end else if (dw_addr == DATA_DW && cfg_en) begin
            if (bus == '0) begin
                if (dev == DEV_W'(HOST_DEV)) begin
                    route    = (fn == '0) ? RT_HOST_SET : RT_NONE;
                    enc_addr = int_addr;
                end else if (dev == DEV_W'(BRIDGE_DEV)) begin
                    route    = (fn == '0) ? RT_BRIDGE_SET : RT_NONE;
                    enc_addr = int_addr;
                end else begin
                    route    = dev_ok ? RT_PRI_T0 : RT_NONE;
                    enc_addr = t0_addr;
                end
            end else if (bus == sec_bus) begin
                route    = dev_ok ? RT_SEC_T0 : RT_NONE;
                enc_addr = t0_addr;
            end else if (bus > sec_bus && bus <= sub_bus) begin
                route    = RT_SEC_T1;
                enc_addr = t1_addr;
            end else begin
                route    = RT_PRI_T1;
                enc_addr = t1_addr;
            end
        end
    end

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
    import cfgr_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT  = 16'h0CFC,
    parameter int          MAX_DEV    = 20,
    parameter int          HOST_DEV   = 0,
    parameter int          BRIDGE_DEV = 1,
    localparam int         DWA_W      = IO_AW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_wr,
    input  logic [DWA_W-1:0] io_dw_addr,
    input  logic [3:0]       io_be,
    input  logic [CA_W-1:0]  io_wdata,
    output logic             io_busy,
    output logic             io_done,
    output logic [CA_W-1:0]  io_rdata,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic             host_sel,
    output logic             bridge_sel,
    output logic             pri_cfg_req,
    output logic             sec_cfg_req,
    output logic             pri_io_req,
    output logic             cyc_type1,
    output logic [CA_W-1:0]  cyc_addr,
    output logic [3:0]       cyc_be,
    output logic             cyc_wr,
    output logic [CA_W-1:0]  cyc_wdata,
    input  logic             tgt_ack,
    input  logic [CA_W-1:0]  tgt_rdata
);

    state_t            state_q, state_d;
    route_t            route_d, route_q;
    logic [CA_W-1:0]   enc_d, enc_q;
    logic              wr_q;
    logic [DWA_W-1:0]  dwa_q;
    logic [3:0]        be_q;
    logic [CA_W-1:0]   wdata_q;
    logic [CA_W-1:0]   rdata_q;
    logic [CA_W-1:0]   cfg_q;
    logic              cfg_wr_en;

    assign cfg_wr_en = (state_q == ST_DECODE) && (route_d == RT_ADDR_WR);

    cfgr_addr_reg u_addr_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (wdata_q),
        .q     (cfg_q)
    );

    cfgr_route_decode #(
        .IO_AW      (IO_AW),
        .ADDR_PORT  (ADDR_PORT),
        .DATA_PORT  (DATA_PORT),
        .MAX_DEV    (MAX_DEV),
        .HOST_DEV   (HOST_DEV),
        .BRIDGE_DEV (BRIDGE_DEV)
    ) u_decode (
        .wr         (wr_q),
        .dw_addr    (dwa_q),
        .be         (be_q),
        .cfg_en     (cfg_q[31]),
        .cfg_fields (cfg_q[23:2]),
        .sec_bus    (sec_bus),
        .sub_bus    (sub_bus),
        .route      (route_d),
        .enc_addr   (enc_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (io_req) state_d = ST_DECODE;
            ST_DECODE:  state_d = route_forwards(route_d) ? ST_ISSUE : ST_RESPOND;
            ST_ISSUE:   state_d = ST_WAIT;
            ST_WAIT:    if (tgt_ack) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            dwa_q   <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            route_q <= RT_NONE;
            enc_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && io_req) begin
                wr_q    <= io_wr;
                dwa_q   <= io_dw_addr;
                be_q    <= io_be;
                wdata_q <= io_wdata;
            end
            if (state_q == ST_DECODE) begin
                route_q <= route_d;
                enc_q   <= enc_d;
                if (route_d == RT_ADDR_RD) begin
                    rdata_q <= cfg_q;
                end else if (route_d == RT_NONE && !wr_q) begin
                    rdata_q <= '1;
                end else begin
                    rdata_q <= '0;
                end
            end
            if (state_q == ST_WAIT && tgt_ack) begin
                rdata_q <= wr_q ? '0 : tgt_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        host_sel    = 1'b0;
        bridge_sel  = 1'b0;
        pri_cfg_req = 1'b0;
        sec_cfg_req = 1'b0;
        pri_io_req  = 1'b0;
        if (state_q == ST_ISSUE) begin
            unique case (route_q)
                RT_HOST_SET:          host_sel    = 1'b1;
                RT_BRIDGE_SET:        bridge_sel  = 1'b1;
                RT_PRI_T0, RT_PRI_T1: pri_cfg_req = 1'b1;
                RT_SEC_T0, RT_SEC_T1: sec_cfg_req = 1'b1;
                RT_PLAIN_IO:          pri_io_req  = 1'b1;
                default:              ;
            endcase
        end
        io_busy   = (state_q != ST_IDLE);
        io_done   = (state_q == ST_RESPOND);
        io_rdata  = rdata_q;
        cyc_type1 = (route_q == RT_PRI_T1) || (route_q == RT_SEC_T1);
        cyc_addr  = enc_q;
        cyc_be    = be_q;
        cyc_wr    = wr_q;
        cyc_wdata = wdata_q;
    end

endmodule

// File: rtl/cfg_cycle_router_chk.sv
module cfg_cycle_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_req,
    input logic        io_busy,
    input logic        io_done,
    input logic [7:0]  sec_bus,
    input logic [7:0]  sub_bus,
    input logic        host_sel,
    input logic        bridge_sel,
    input logic        pri_cfg_req,
    input logic        sec_cfg_req,
    input logic        pri_io_req,
    input logic        cyc_type1,
    input logic [31:0] cyc_addr
);

    logic any_strobe;
    logic cfg_strobe;
    assign any_strobe = host_sel | bridge_sel | pri_cfg_req | sec_cfg_req | pri_io_req;
    assign cfg_strobe = pri_cfg_req | sec_cfg_req;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_sel, bridge_sel, pri_cfg_req, sec_cfg_req, pri_io_req})); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> (!io_done && !io_busy)); // R2

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_busy) |=> io_busy); // R2

    AST_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> (cyc_addr[1:0] == {1'b0, cyc_type1})); // R8

    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_strobe && !cyc_type1) |-> ($countones(cyc_addr[31:11]) == 1)); // R6

    AST_SEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_cfg_req && cyc_type1) |->
            (cyc_addr[23:16] > sec_bus && cyc_addr[23:16] <= sub_bus)); // R8

    AST_INTERNAL_FN0: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel || bridge_sel) |-> (cyc_addr[10:8] == 3'd0 && cyc_addr[31:11] == '0)); // R4

endmodule

bind cfg_cycle_router cfg_cycle_router_chk u_chk (.*);

// File: tb/cfg_cycle_router_bench.sv
`timescale 1ns/1ps
module cfg_cycle_router_bench;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [13:0] io_dw_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_busy, io_done;
    logic [31:0] io_rdata;
    logic [7:0]  sec_bus = 8'd1, sub_bus = 8'd4;
    logic        host_sel, bridge_sel, pri_cfg_req, sec_cfg_req, pri_io_req, cyc_type1;
    logic [31:0] cyc_addr, cyc_wdata;
    logic [3:0]  cyc_be;
    logic        cyc_wr;
    logic        tgt_ack = 1'b0;
    logic [31:0] tgt_rdata = '0;

    int n_checks = 0, n_fail = 0;
    logic [31:0] ca_model = '0;

    localparam logic [13:0] DW_ADDR = 14'h033E;
    localparam logic [13:0] DW_DATA = 14'h033F;

    // kinds: 0 addr wr, 1 addr rd, 2 unclaimed, 3 host, 4 bridge, 5 pri cfg, 6 sec cfg, 7 plain io
    always #(CLK_P/2) clk = ~clk;

    cfg_cycle_router u_cfg_cycle_router (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input bit wr, input logic [13:0] dwa, input logic [3:0] be,
                                  output int kind, output logic [31:0] ea, output bit t1,
                                  output string req);
        logic [7:0] bus; logic [4:0] dev; logic [2:0] fn; logic [5:0] rg;
        bus = ca_model[23:16]; dev = ca_model[15:11]; fn = ca_model[10:8]; rg = ca_model[7:2];
        t1 = 1'b0; ea = {16'h0, dwa, 2'b00}; kind = 7; req = "R3";
        if (dwa == DW_ADDR && be == 4'hF) begin
            kind = wr ? 0 : 1; req = "R1";
        end else if (dwa == DW_DATA && ca_model[31]) begin
            if (bus == 0 && (dev == 0 || dev == 1)) begin
                ea = {21'h0, fn, rg, 2'b00};
                if (fn != 0) begin kind = 2; req = "R5"; end
                else begin kind = (dev == 0) ? 3 : 4; req = "R4"; end
            end else if (bus == 0 || bus == sec_bus) begin
                req = (bus == 0) ? "R6" : "R7";
                ea = (dev <= 20) ? (32'h1 << (11 + dev)) | {21'h0, fn, rg, 2'b00} : 32'h0;
                kind = (dev > 20) ? 2 : ((bus == 0) ? 5 : 6);
            end else begin
                t1 = 1'b1;
                ea = {8'h00, bus, dev, fn, rg, 2'b01};
                if (bus > sec_bus && bus <= sub_bus) begin kind = 6; req = "R8"; end
                else begin kind = 5; req = "R9"; end
            end
        end
    endfunction

    task automatic access(input bit wr, input logic [13:0] dwa, input logic [3:0] be, input logic [31:0] wd);
        int ekind, gkind, nstr; logic [31:0] eaddr, gaddr, rsp, rd, erd; bit et1, gt1, done, ackp;
        logic [3:0] gbe; bit gwr; logic [31:0] gwd; string req;
        model(wr, dwa, be, ekind, eaddr, et1, req);
        rsp = $urandom; gkind = -1; nstr = 0; done = 0; ackp = 0;
        gaddr = '0; gt1 = 0; gbe = '0; gwr = 0; gwd = '0; rd = '0;
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_dw_addr = dwa; io_be = be; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (ackp) begin tgt_ack = 1'b1; tgt_rdata = rsp; ackp = 0; end
            else tgt_ack = 1'b0;
            if (host_sel | bridge_sel | pri_cfg_req | sec_cfg_req | pri_io_req) begin
                nstr++;
                gkind = host_sel ? 3 : bridge_sel ? 4 : pri_cfg_req ? 5 : sec_cfg_req ? 6 : 7;
                gaddr = cyc_addr; gt1 = cyc_type1; gbe = cyc_be; gwr = cyc_wr; gwd = cyc_wdata;
                ackp = 1;
            end
            if (io_done) begin done = 1; rd = io_rdata; end
            else @(negedge clk);
        end
        tgt_ack = 1'b0;
        check(done, "R2 done", 32'(done), 32'd1);
        if (ekind >= 3) begin
            check(nstr == 1 && gkind == ekind, {req, " target"}, 32'(gkind), 32'(ekind));
            check(gaddr == eaddr && gt1 == et1, {req, " cyc_addr"}, gaddr, eaddr);
            check(gbe == be && gwr == wr && (!wr || gwd == wd), "R10 be/wr/data", {gbe, 27'(gwd)}, {be, 27'(wd)});
            erd = wr ? 32'h0 : rsp;
        end else begin
            check(nstr == 0, {req, " no strobe"}, 32'(nstr), 32'd0);
            erd = wr ? 32'h0 : (ekind == 1) ? ca_model : 32'hFFFF_FFFF;
        end
        check(rd == erd, {req, " rdata"}, rd, erd);
        if (ekind == 0) ca_model = wd & 32'h80FF_FFFC;
    endtask

    task automatic set_addr(input bit en, input logic [7:0] bus, input logic [4:0] dev,
                            input logic [2:0] fn, input logic [5:0] rg);
        access(1'b1, DW_ADDR, 4'hF, {en, 7'h55, bus, dev, fn, rg, 2'b11});
    endtask

    function automatic logic [7:0] pick_bus();
        unique case ($urandom % 5)
            0: return 8'd0;
            1: return sec_bus;
            2: return (sub_bus > sec_bus) ? 8'(sec_bus + 1 + ($urandom % (sub_bus - sec_bus))) : sec_bus;
            3: return 8'(sub_bus + 1);
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            logic [4:0] dev;
            dev = ($urandom % 3 == 0) ? 5'($urandom % 2) : 5'($urandom);
            set_addr(($urandom % 6) != 0, pick_bus(), dev, 3'($urandom % 3 == 0 ? $urandom : 0), 6'($urandom));
            if ($urandom % 8 == 0)
                access($urandom % 2, 14'($urandom), 4'($urandom | 1), $urandom);
            else
                access($urandom % 2, DW_DATA, 4'($urandom | 1), $urandom);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_done && !io_busy, "R2 reset idle", {30'h0, io_busy, io_done}, 32'h0);
        check(!(host_sel | bridge_sel | pri_cfg_req | sec_cfg_req | pri_io_req), "R10 reset strobes", 32'h0, 32'h0);
        access(1'b0, DW_ADDR, 4'hF, 32'h0);                    // R1 reset value
        access(1'b1, DW_ADDR, 4'hF, 32'hFFFF_FFFF);             // R1 masking
        access(1'b0, DW_ADDR, 4'hF, 32'h0);
        access(1'b1, DW_ADDR, 4'h3, 32'h1234_5678);             // R3 partial lanes
        set_addr(1'b0, 8'd0, 5'd0, 3'd0, 6'd4);
        access(1'b0, DW_DATA, 4'hF, 32'h0);                     // R3 enable clear
        set_addr(1'b1, 8'd0, 5'd0, 3'd0, 6'd2);  access(1'b0, DW_DATA, 4'hF, 32'h0);        // R4
        set_addr(1'b1, 8'd0, 5'd1, 3'd0, 6'd6);  access(1'b1, DW_DATA, 4'h4, 32'hA5A5_0000); // R4
        set_addr(1'b1, 8'd0, 5'd0, 3'd3, 6'd1);  access(1'b1, DW_DATA, 4'hF, 32'hDEAD_BEEF); // R5
        access(1'b0, DW_DATA, 4'hF, 32'h0);                                                  // R5
        set_addr(1'b1, 8'd0, 5'd20, 3'd1, 6'd9); access(1'b0, DW_DATA, 4'hF, 32'h0);        // R6 top device
        set_addr(1'b1, 8'd0, 5'd21, 3'd0, 6'd0); access(1'b0, DW_DATA, 4'hF, 32'h0);        // R6 unclaimed
        set_addr(1'b1, 8'd1, 5'd3, 3'd2, 6'd5);  access(1'b0, DW_DATA, 4'hF, 32'h0);        // R7
        set_addr(1'b1, 8'd4, 5'd7, 3'd0, 6'd1);  access(1'b1, DW_DATA, 4'hF, 32'h0BAD_F00D); // R8 top of window
        set_addr(1'b1, 8'd5, 5'd7, 3'd0, 6'd1);  access(1'b0, DW_DATA, 4'hF, 32'h0);        // R9 above window
        random_phase(150);
        sec_bus = 8'd3; sub_bus = 8'd3;
        random_phase(80);
        sec_bus = 8'd0; sub_bus = 8'd0;
        set_addr(1'b1, 8'd2, 5'd0, 3'd0, 6'd0);  access(1'b0, DW_DATA, 4'hF, 32'h0);        // R9 unconfigured bridge
        random_phase(60);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule